// File: doc/BRIEF.md
# Opcode-Indexed Precomputed Result Table

This block is a read-mostly lookup table of instruction results, used to check or stand in for a second execution of an instruction. A loader fills it before the program starts. Each table entry holds a pair of operand values and the result the operation produced for them. Once execution begins, the table is only read.

The table is organised as a number of associative sets. A directory indexed by opcode keeps, for every opcode, a short list of the sets that belong to it. A frequent opcode can therefore claim several sets, up to a fixed cap, while a rare opcode claims one or none. Every entry in a set belongs to the opcode that owns the set.

A lookup presents an opcode and two operands. The directory names the opcode's sets, and every way of every listed set is compared in parallel. Hit and result are registered and appear on the clock edge after the request. For opcodes marked commutative at load time, a stored pair also matches when the operands arrive in swapped order. Load requests that break the ownership rules are dropped and raise a one-cycle error flag.

Top module: `opres_table`

## Requirements
- R1: After reset, lk_hit and ld_err are 0, no set is owned by any opcode, and every entry is invalid.
- R2: One cycle after a lookup (lk_valid=1, load_active=0), lk_hit is 1 and lk_result carries the stored result if a valid entry in a set listed for lk_opcode holds operands equal to (lk_a, lk_b). Otherwise lk_hit is 0 and lk_result is 0. A cycle without lk_valid gives lk_hit=0 on the next cycle.
- R3: The sets listed for one opcode are all searched. An entry in any of them produces a hit.
- R4: An opcode lists at most LIST_N sets. An assign request (ld_kind=0) that would add another set is dropped and raises ld_err.
- R5: The ld_comm bit of an accepted assign sets the opcode's commutative flag. When the flag is set, a lookup with the operands swapped relative to the stored pair also hits. When it is clear, the swapped lookup misses.
- R6: A lookup made while load_active=1 returns lk_hit=0.
- R7: An assign request or an entry write (ld_kind=1) whose ld_set is NUM_SETS or above is dropped, and ld_err is 1 on the next cycle.
- R8: An assign naming a set owned by another opcode is dropped with ld_err. So is an entry write to a set that is unowned or owned by a different opcode.
- R9: Load requests are acted on only while load_active=1. With load_active=0 they change nothing and leave ld_err at 0. Lookups never alter the contents.
- R10: If several entries match, the result comes from the earliest-assigned listed set, and within that set from the lowest way.
- R11: An entry that was never written never hits, whatever its operand fields hold.
- R12: Assigning a set again to the opcode that already owns it is accepted without error and takes no further list slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_active | input | 1 | High while the loader fills the table |
| ld_valid | input | 1 | Load request valid |
| ld_kind | input | 1 | 0 = assign set to opcode, 1 = write entry |
| ld_opcode | input | OPC_W | Opcode of the load request |
| ld_set | input | $clog2(NUM_SETS)+1 | Target set index (wide enough to express out-of-range values) |
| ld_way | input | $clog2(WAYS) | Target way for an entry write |
| ld_comm | input | 1 | Commutative flag carried by an assign |
| ld_a | input | DATA_W | First operand of the entry |
| ld_b | input | DATA_W | Second operand of the entry |
| ld_result | input | DATA_W | Result of the entry |
| ld_err | output | 1 | One-cycle pulse: previous load request was dropped |
| lk_valid | input | 1 | Lookup request valid |
| lk_opcode | input | OPC_W | Lookup opcode |
| lk_a | input | DATA_W | Lookup first operand |
| lk_b | input | DATA_W | Lookup second operand |
| lk_hit | output | 1 | Registered hit for the previous cycle's lookup |
| lk_result | output | DATA_W | Registered result (0 on miss) |

## Verification
The checker watches, on every cycle, the properties that need no knowledge of the table contents. These are the reset state, zero results on a miss, no hit without a request or while loading, no error from idle load traffic, and the error pulse for out-of-range set indices. Properties that depend on contents only show up in the bench scenarios. These are the ownership and list-cap rules, the search across several sets, the commutative swap, the priority among duplicate keys, the invisibility of unwritten entries and the immunity of the contents once loading ends.

// File: rtl/opres_pkg.sv
// Shared definitions for the precomputed result table.
// Assumes: single load port, one request per cycle.
package opres_pkg;
    typedef enum logic {
        LOAD_ASSIGN = 1'b0,
        LOAD_ENTRY  = 1'b1
    } load_kind_e;
endpackage

// File: rtl/opres_dir.sv
// Opcode directory and set-ownership map.
// Holds per opcode a list of up to LIST_N owned sets plus a commutative flag,
// and per set its owning opcode. Validates load requests against these.
// Assumes: requests arrive already qualified by load_active.
module opres_dir #(
    parameter int OPC_W    = 4,
    parameter int NUM_SETS = 8,
    parameter int LIST_N   = 2,
    parameter int SEL_W    = 3,
    parameter int LDS_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             asg_req,
    input  logic             ent_req,
    input  logic [OPC_W-1:0] ld_opcode,
    input  logic [LDS_W-1:0] ld_set,
    input  logic             ld_comm,
    input  logic [OPC_W-1:0] lk_opcode,
    output logic [SEL_W-1:0] lk_sets [LIST_N],
    output logic [LIST_N-1:0] lk_setv,
    output logic             lk_comm,
    output logic             ent_ok,
    output logic             reject
);
    localparam int NUM_OPS = 1 << OPC_W;
    localparam int SLOT_W  = (LIST_N > 1) ? $clog2(LIST_N) : 1;

    logic [NUM_SETS-1:0] own_v;
    logic [OPC_W-1:0]    own_op   [NUM_SETS];
    logic [SEL_W-1:0]    slot_set [NUM_OPS][LIST_N];
    logic [LIST_N-1:0]   slot_v   [NUM_OPS];
    logic [NUM_OPS-1:0]  comm_q;

    logic             in_range, owned, same, has_free, take;
    logic [SEL_W-1:0] set_lo;
    logic [SLOT_W-1:0] free_slot;

    // Decode ownership of the requested set and find the opcode's first free slot.
    always_comb begin
        in_range  = ld_set < LDS_W'(NUM_SETS);
        set_lo    = ld_set[SEL_W-1:0];
        owned     = in_range && own_v[set_lo];
        same      = owned && (own_op[set_lo] == ld_opcode);
        has_free  = 1'b0;
        free_slot = '0;
        for (int i = LIST_N - 1; i >= 0; i--) begin
            if (!slot_v[ld_opcode][i]) begin
                has_free  = 1'b1;
                free_slot = SLOT_W'(i);
            end
        end
        take   = asg_req && in_range && !owned && has_free;
        ent_ok = same;
        reject = (asg_req && !(same || take)) || (ent_req && !same);
    end

    // Valid bits and flags: cleared by reset, set by an accepted assign.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_v  <= '0;
            comm_q <= '0;
            for (int o = 0; o < NUM_OPS; o++) slot_v[o] <= '0;
        end else if (take) begin
            own_v[set_lo]               <= 1'b1;
            slot_v[ld_opcode][free_slot] <= 1'b1;
            comm_q[ld_opcode]           <= ld_comm;
        end
    end

    // Payload of an accepted assign: owner opcode and listed set index.
    always_ff @(posedge clk) begin
        if (take) begin
            own_op[set_lo]                 <= ld_opcode;
            slot_set[ld_opcode][free_slot] <= set_lo;
        end
    end

    // Read port for lookups.
    always_comb begin
        for (int j = 0; j < LIST_N; j++) lk_sets[j] = slot_set[lk_opcode][j];
        lk_setv = slot_v[lk_opcode];
        lk_comm = comm_q[lk_opcode];
    end
endmodule

// File: rtl/opres_store.sv
// Entry storage: NUM_SETS x WAYS entries of (operand a, operand b, result).
// Only the valid bits are reset; data is undefined until written.
// Assumes: the write set index has been range-checked by the directory.
module opres_store #(
    parameter int NUM_SETS = 8,
    parameter int WAYS     = 4,
    parameter int DATA_W   = 64,
    parameter int SEL_W    = 3,
    parameter int WAY_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  wset,
    input  logic [WAY_W-1:0]  wway,
    input  logic [DATA_W-1:0] wa,
    input  logic [DATA_W-1:0] wb,
    input  logic [DATA_W-1:0] wr,
    output logic [WAYS-1:0]   ent_v [NUM_SETS],
    output logic [DATA_W-1:0] ent_a [NUM_SETS][WAYS],
    output logic [DATA_W-1:0] ent_b [NUM_SETS][WAYS],
    output logic [DATA_W-1:0] ent_r [NUM_SETS][WAYS]
);
    // Entry valid bits: cleared by reset, set by a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) ent_v[s] <= '0;
        end else if (we) begin
            ent_v[wset][wway] <= 1'b1;
        end
    end

    // Entry payload write.
    always_ff @(posedge clk) begin
        if (we) begin
            ent_a[wset][wway] <= wa;
            ent_b[wset][wway] <= wb;
            ent_r[wset][wway] <= wr;
        end
    end
endmodule

// File: rtl/opres_match.sv
// Parallel search of every way of every listed set, with optional swapped
// operand compare. Picks the lowest list slot, then the lowest way.
// Purely combinational.
module opres_match #(
    parameter int NUM_SETS = 8,
    parameter int WAYS     = 4,
    parameter int DATA_W   = 64,
    parameter int SEL_W    = 3,
    parameter int LIST_N   = 2
) (
    input  logic [WAYS-1:0]   ent_v [NUM_SETS],
    input  logic [DATA_W-1:0] ent_a [NUM_SETS][WAYS],
    input  logic [DATA_W-1:0] ent_b [NUM_SETS][WAYS],
    input  logic [DATA_W-1:0] ent_r [NUM_SETS][WAYS],
    input  logic [SEL_W-1:0]  lk_sets [LIST_N],
    input  logic [LIST_N-1:0] lk_setv,
    input  logic              lk_comm,
    input  logic [DATA_W-1:0] lk_a,
    input  logic [DATA_W-1:0] lk_b,
    output logic              hit,
    output logic [DATA_W-1:0] result
);
    logic [WAYS-1:0] way_hit [LIST_N];

    for (genvar g = 0; g < LIST_N; g++) begin : g_slot
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            logic direct, swapped;
            // Compare one way of one listed set in both operand orders.
            always_comb begin
                direct  = (ent_a[lk_sets[g]][w] == lk_a) && (ent_b[lk_sets[g]][w] == lk_b);
                swapped = (ent_a[lk_sets[g]][w] == lk_b) && (ent_b[lk_sets[g]][w] == lk_a);
                way_hit[g][w] = lk_setv[g] && ent_v[lk_sets[g]][w] &&
                                (direct || (lk_comm && swapped));
            end
        end
    end

    // Priority select: last assignment in the descending scan is the lowest slot/way.
    always_comb begin
        hit    = 1'b0;
        result = '0;
        for (int g = LIST_N - 1; g >= 0; g--) begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (way_hit[g][w]) begin
                    hit    = 1'b1;
                    result = ent_r[lk_sets[g]][w];
                end
            end
        end
    end
endmodule

// File: rtl/opres_table.sv
// Opcode-indexed precomputed result table (top).
// Load port fills directory and entries while load_active is high; lookups
// are answered with a registered hit/result one cycle later.
// Assumes: one load request and one lookup per cycle at most.
module opres_table
    import opres_pkg::*;
#(
    parameter int OPC_W    = 4,
    parameter int DATA_W   = 64,
    parameter int NUM_SETS = 8,
    parameter int WAYS     = 4,
    parameter int LIST_N   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_active,
    input  logic                          ld_valid,
    input  logic                          ld_kind,
    input  logic [OPC_W-1:0]              ld_opcode,
    input  logic [$clog2(NUM_SETS):0]     ld_set,
    input  logic [$clog2(WAYS)-1:0]       ld_way,
    input  logic                          ld_comm,
    input  logic [DATA_W-1:0]             ld_a,
    input  logic [DATA_W-1:0]             ld_b,
    input  logic [DATA_W-1:0]             ld_result,
    output logic                          ld_err,
    input  logic                          lk_valid,
    input  logic [OPC_W-1:0]              lk_opcode,
    input  logic [DATA_W-1:0]             lk_a,
    input  logic [DATA_W-1:0]             lk_b,
    output logic                          lk_hit,
    output logic [DATA_W-1:0]             lk_result
);
    localparam int SEL_W = $clog2(NUM_SETS);
    localparam int LDS_W = SEL_W + 1;
    localparam int WAY_W = $clog2(WAYS);

    logic              go, asg_req, ent_req, ent_ok, reject, we;
    logic [SEL_W-1:0]  lk_sets [LIST_N];
    logic [LIST_N-1:0] lk_setv;
    logic              lk_comm, m_hit;
    logic [DATA_W-1:0] m_res;
    logic [WAYS-1:0]   ent_v [NUM_SETS];
    logic [DATA_W-1:0] ent_a [NUM_SETS][WAYS];
    logic [DATA_W-1:0] ent_b [NUM_SETS][WAYS];
    logic [DATA_W-1:0] ent_r [NUM_SETS][WAYS];

    // Qualify load requests: only acted on during the load phase.
    always_comb begin
        go      = ld_valid && load_active;
        asg_req = go && (load_kind_e'(ld_kind) == LOAD_ASSIGN);
        ent_req = go && (load_kind_e'(ld_kind) == LOAD_ENTRY);
        we      = ent_req && ent_ok;
    end

    opres_dir #(
        .OPC_W(OPC_W), .NUM_SETS(NUM_SETS), .LIST_N(LIST_N),
        .SEL_W(SEL_W), .LDS_W(LDS_W)
    ) u_dir (
        .clk(clk), .rst_n(rst_n), .asg_req(asg_req), .ent_req(ent_req),
        .ld_opcode(ld_opcode), .ld_set(ld_set), .ld_comm(ld_comm),
        .lk_opcode(lk_opcode), .lk_sets(lk_sets), .lk_setv(lk_setv),
        .lk_comm(lk_comm), .ent_ok(ent_ok), .reject(reject)
    );

    opres_store #(
        .NUM_SETS(NUM_SETS), .WAYS(WAYS), .DATA_W(DATA_W),
        .SEL_W(SEL_W), .WAY_W(WAY_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .we(we), .wset(ld_set[SEL_W-1:0]),
        .wway(ld_way), .wa(ld_a), .wb(ld_b), .wr(ld_result),
        .ent_v(ent_v), .ent_a(ent_a), .ent_b(ent_b), .ent_r(ent_r)
    );

    opres_match #(
        .NUM_SETS(NUM_SETS), .WAYS(WAYS), .DATA_W(DATA_W),
        .SEL_W(SEL_W), .LIST_N(LIST_N)
    ) u_match (
        .ent_v(ent_v), .ent_a(ent_a), .ent_b(ent_b), .ent_r(ent_r),
        .lk_sets(lk_sets), .lk_setv(lk_setv), .lk_comm(lk_comm),
        .lk_a(lk_a), .lk_b(lk_b), .hit(m_hit), .result(m_res)
    );

    // Output registers: lookup response and load error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_hit    <= 1'b0;
            lk_result <= '0;
            ld_err    <= 1'b0;
        end else begin
            lk_hit    <= lk_valid && !load_active && m_hit;
            lk_result <= (lk_valid && !load_active && m_hit) ? m_res : '0;
            ld_err    <= reject;
        end
    end
endmodule

// File: rtl/opres_table_checker.sv
// Port-level properties of the result table, bound to every instance.
module opres_table_checker #(
    parameter int OPC_W    = 4,
    parameter int DATA_W   = 64,
    parameter int NUM_SETS = 8,
    parameter int WAYS     = 4,
    parameter int LIST_N   = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      load_active,
    input logic                      ld_valid,
    input logic [$clog2(NUM_SETS):0] ld_set,
    input logic                      ld_err,
    input logic                      lk_valid,
    input logic                      lk_hit,
    input logic [DATA_W-1:0]         lk_result
);
    localparam int LDS_W = $clog2(NUM_SETS) + 1;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!lk_hit && !ld_err));

    assert_miss_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_result == '0));

    assert_no_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !lk_hit);

    assert_load_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && load_active) |=> !lk_hit);

    assert_range_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && load_active && (ld_set >= LDS_W'(NUM_SETS))) |=> ld_err);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ld_valid && load_active)) |=> !ld_err);
endmodule

bind opres_table opres_table_checker #(
    .OPC_W(OPC_W), .DATA_W(DATA_W), .NUM_SETS(NUM_SETS),
    .WAYS(WAYS), .LIST_N(LIST_N)
) u_chk (
    .clk(clk), .rst_n(rst_n), .load_active(load_active), .ld_valid(ld_valid),
    .ld_set(ld_set), .ld_err(ld_err), .lk_valid(lk_valid),
    .lk_hit(lk_hit), .lk_result(lk_result)
);

// File: tb/opres_table_test.sv
`timescale 1ns/100ps
// Scenario bench for the result table at its default configuration
// (16 opcodes, 8 sets x 4 ways, 2 sets per opcode). Expected results are
// computed arithmetically from opcode and operands.
module opres_table_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_active = 1'b0;
    logic        ld_valid = 1'b0, ld_kind = 1'b0, ld_comm = 1'b0;
    logic [3:0]  ld_opcode = '0, ld_set = '0;
    logic [1:0]  ld_way = '0;
    logic [63:0] ld_a = '0, ld_b = '0, ld_result = '0;
    logic        ld_err;
    logic        lk_valid = 1'b0;
    logic [3:0]  lk_opcode = '0;
    logic [63:0] lk_a = '0, lk_b = '0;
    logic        lk_hit;
    logic [63:0] lk_result;

    int checks = 0;
    int errors = 0;

    opres_table uut (
        .clk(clk), .rst_n(rst_n), .load_active(load_active),
        .ld_valid(ld_valid), .ld_kind(ld_kind), .ld_opcode(ld_opcode),
        .ld_set(ld_set), .ld_way(ld_way), .ld_comm(ld_comm),
        .ld_a(ld_a), .ld_b(ld_b), .ld_result(ld_result), .ld_err(ld_err),
        .lk_valid(lk_valid), .lk_opcode(lk_opcode), .lk_a(lk_a), .lk_b(lk_b),
        .lk_hit(lk_hit), .lk_result(lk_result)
    );

    always #2.5 clk = ~clk;

    function automatic logic [63:0] fres(int op, logic [63:0] a, logic [63:0] b);
        return a * 64'd3 + (b << 2) + 64'(op * 17);
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic assign_set(int op, int set, bit comm, bit exp_err, string tag);
        ld_valid = 1'b1; ld_kind = 1'b0; ld_opcode = 4'(op);
        ld_set = 4'(set); ld_comm = comm;
        @(negedge clk);
        ld_valid = 1'b0;
        chk(tag, 64'(ld_err), 64'(exp_err));
    endtask

    task automatic write_ent(int op, int set, int way, logic [63:0] a, logic [63:0] b,
                             logic [63:0] r, bit exp_err, string tag);
        ld_valid = 1'b1; ld_kind = 1'b1; ld_opcode = 4'(op); ld_set = 4'(set);
        ld_way = 2'(way); ld_a = a; ld_b = b; ld_result = r;
        @(negedge clk);
        ld_valid = 1'b0;
        chk(tag, 64'(ld_err), 64'(exp_err));
    endtask

    task automatic look(int op, logic [63:0] a, logic [63:0] b, bit exp_hit,
                        logic [63:0] exp_res, string tag);
        lk_valid = 1'b1; lk_opcode = 4'(op); lk_a = a; lk_b = b;
        @(negedge clk);
        lk_valid = 1'b0;
        chk({tag, " hit"}, 64'(lk_hit), 64'(exp_hit));
        chk({tag, " result"}, lk_result, exp_res);
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset hit", 64'(lk_hit), 64'd0);
        chk("R1 reset err", 64'(ld_err), 64'd0);
        look(0, 64'd0, 64'd0, 1'b0, 64'd0, "R1 R11 empty table");

        load_active = 1'b1;
        // Directory construction and its rejection rules.
        assign_set(1, 0, 1'b1, 1'b0, "R3 op1 set0");
        assign_set(1, 1, 1'b1, 1'b0, "R3 op1 set1");
        assign_set(1, 4, 1'b1, 1'b1, "R4 op1 third set");
        assign_set(2, 2, 1'b0, 1'b0, "R5 op2 set2");
        assign_set(3, 3, 1'b0, 1'b0, "R3 op3 set3");
        assign_set(5, 9, 1'b0, 1'b1, "R7 assign out of range");
        assign_set(2, 0, 1'b0, 1'b1, "R8 assign foreign set");
        assign_set(3, 3, 1'b0, 1'b0, "R12 same owner again");
        assign_set(3, 5, 1'b0, 1'b0, "R12 slot still free");
        assign_set(3, 6, 1'b0, 1'b1, "R4 op3 cap");
        write_ent(1, 6, 0, 64'd1, 64'd2, 64'd3, 1'b1, "R8 write unowned set");
        write_ent(2, 0, 0, 64'd1, 64'd2, 64'd3, 1'b1, "R8 write foreign set");
        write_ent(1, 12, 0, 64'd1, 64'd2, 64'd3, 1'b1, "R7 write out of range");

        // Fill op1 sets 0 and 1 fully.
        for (int k = 0; k < 8; k++) begin
            logic [63:0] a, b;
            a = 64'(k + 1); b = 64'(k + 1000);
            write_ent(1, k / 4, k % 4, a, b, fres(1, a, b), 1'b0, "R3 fill op1");
        end
        // Fill op2 set 2.
        for (int w = 0; w < 4; w++)
            write_ent(2, 2, w, 64'(w + 20), 64'(w + 40), fres(2, 64'(w + 20), 64'(w + 40)),
                      1'b0, "R5 fill op2");
        // op3: duplicate key in ways 0 and 1 of set 3; one entry in set 5.
        write_ent(3, 3, 0, 64'd50, 64'd51, 64'd111, 1'b0, "R10 dup way0");
        write_ent(3, 3, 1, 64'd50, 64'd51, 64'd222, 1'b0, "R10 dup way1");
        write_ent(3, 5, 0, 64'd60, 64'd61, fres(3, 64'd60, 64'd61), 1'b0, "R3 op3 set5");
        // Shadow copy of op1 key (1,1000) in the second listed set.
        write_ent(1, 1, 3, 64'd1, 64'd1000, 64'hDEAD, 1'b0, "R10 shadow write");

        look(1, 64'd1, 64'd1000, 1'b0, 64'd0, "R6 lookup during load");
        load_active = 1'b0;

        // Loads with load_active low are ignored.
        write_ent(1, 0, 0, 64'd1, 64'd1000, 64'hBEEF, 1'b0, "R9 idle write");
        assign_set(4, 7, 1'b0, 1'b0, "R9 idle assign");
        look(1, 64'd1, 64'd1000, 1'b1, fres(1, 64'd1, 64'd1000), "R9 R10 list priority");

        // Sweep op1: key 7 was replaced by the shadow copy.
        for (int k = 0; k < 8; k++) begin
            logic [63:0] a, b;
            a = 64'(k + 1); b = 64'(k + 1000);
            if (k == 7) look(1, a, b, 1'b0, 64'd0, "R2 overwritten key");
            else        look(1, a, b, 1'b1, fres(1, a, b), "R2 R3 op1 sweep");
        end
        for (int k = 0; k < 7; k++) begin
            logic [63:0] a, b;
            a = 64'(k + 1); b = 64'(k + 1000);
            look(1, b, a, 1'b1, fres(1, a, b), "R5 commutative swap");
        end
        for (int w = 0; w < 4; w++) begin
            look(2, 64'(w + 20), 64'(w + 40), 1'b1, fres(2, 64'(w + 20), 64'(w + 40)),
                 "R2 op2 direct");
            look(2, 64'(w + 40), 64'(w + 20), 1'b0, 64'd0, "R5 non-commutative swap");
        end
        look(3, 64'd50, 64'd51, 1'b1, 64'd111, "R10 way priority");
        look(3, 64'd60, 64'd61, 1'b1, fres(3, 64'd60, 64'd61), "R3 op3 second set");
        look(3, 64'd0, 64'd0, 1'b0, 64'd0, "R11 unwritten way");
        look(2, 64'd1, 64'd1000, 1'b0, 64'd0, "R2 opcode mismatch");

        lk_opcode = 4'd1; lk_a = 64'd2; lk_b = 64'd1001; lk_valid = 1'b0;
        @(negedge clk);
        chk("R2 no request", 64'(lk_hit), 64'd0);

        // The idle assign of set 7 must not have taken effect.
        load_active = 1'b1;
        write_ent(4, 7, 0, 64'd5, 64'd5, 64'd5, 1'b1, "R9 idle assign ignored");
        load_active = 1'b0;

        summary();
        $finish;
    end
endmodule